// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and a shift register of recent branch outcomes across the whole program. The counter for a lookup is chosen by XOR-ing a slice of the branch address with that history. Because the history takes part in the index, one branch can use different counters depending on what recent branches did. A pattern that defeats a plain per-address counter, such as strict alternation, can therefore be learned.

The fetch side presents an address and receives a direction in the same cycle. It also receives the history value in use at that moment, and the pipeline carries that value along with the branch. A valid lookup shifts its own predicted direction into the history right away, so the next fetch already sees it. When the branch resolves, the execute side returns the address, the real outcome, the carried history and a misprediction flag. The counter chosen by the carried history is trained. On a misprediction the history register is rebuilt from the carried value plus the real outcome.

Top module: `gshare_predictor`

## Requirements
- R1: While reset is asserted and after it is released, the history register reads zero and every counter holds 2 (weakly taken), so every lookup predicts taken until a resolve trains it.
- R2: The lookup index is `lk_addr[ADDR_LSB +: IDX_W]` XOR the history, where the history is zero-extended at the top when it is narrower than the index. `lk_taken` is bit 1 of the selected counter. Counter encoding: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken.
- R3: A resolve with `rs_taken`=1 raises the selected counter by one, stopping at 3. A resolve with `rs_taken`=0 lowers it by one, stopping at 0.
- R4: A resolve trains the counter indexed by `rs_addr` XOR `rs_hist`, whatever the current history is. No other counter changes.
- R5: `lk_hist` shows the current history. A cycle with `lk_valid`=1 and no misprediction restore makes the next history `{lk_hist[HIST_W-2:0], lk_taken}`.
- R6: A cycle with `rs_valid`=1 and `rs_mispred`=1 makes the next history `{rs_hist[HIST_W-2:0], rs_taken}`. This takes priority over a lookup shift in the same cycle.
- R7: A cycle with no lookup and no misprediction restore leaves the history unchanged. This includes cycles with a resolve whose `rs_mispred`=0.
- R8: If a branch at one address alternates taken/not taken, and each prediction is resolved before the next lookup, the predictions become correct for every instance once trained.
- R9: When a lookup and a resolve select the same counter in the same cycle, the lookup sees the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A predicted branch is fetched this cycle |
| lk_addr | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | HIST_W | History snapshot to carry with the branch |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |
| rs_hist | input | HIST_W | Snapshot that was carried with the branch |
| rs_mispred | input | 1 | The resolved branch was mispredicted; restore history |

## Verification
The hardest states to reach are those where the history the table was trained with is not the current history. This covers a resolve carrying an old snapshot, a misprediction restore in the same cycle as a new lookup, and a lookup and a resolve that meet on one counter. The bench drives these cases directly, with snapshots chosen to differ from the live register. It then runs a long pseudorandom mix of lookups, resolves and restores on a 16-entry table. Every cycle, the bench compares the direction and history against its own arithmetic model. An alternating branch closes the loop, with each resolve fed back from the snapshot the design returned.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'd0;
   localparam ctr_t CTR_WEAK_T    = 2'd2;
   localparam ctr_t CTR_STRONG_T  = 2'd3;

   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
   parameter int ADDR_W   = 32,
   parameter int ADDR_LSB = 2,
   parameter int IDX_W    = 8,
   parameter int HIST_W   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  idx
);

   logic [IDX_W-1:0] addr_bits;
   logic             unused_addr;

   assign addr_bits   = addr[ADDR_LSB +: IDX_W];
   assign unused_addr = ^addr;

   generate
      if (HIST_W == IDX_W) begin : g_full
         assign idx = addr_bits ^ hist;
      end else begin : g_pad
         assign idx = addr_bits ^ {{(IDX_W-HIST_W){1'b0}}, hist};
      end
   endgenerate

endmodule

// File: rtl/gshare_hist.sv
module gshare_hist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic              restore_en,
   input  logic [HIST_W-2:0] restore_base,
   input  logic              restore_bit,
   output logic [HIST_W-1:0] hist_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)          hist_q <= '0;
      else if (restore_en) hist_q <= {restore_base, restore_bit};
      else if (shift_en)   hist_q <= {hist_q[HIST_W-2:0], shift_bit};
   end

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
   import gshare_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] dir_bits;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         ctr_t ctr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ctr_q <= CTR_WEAK_T;
            else if (wr_en && (wr_idx == IDX_W'(e)))
               ctr_q <= ctr_next(ctr_q, wr_taken);
         end
         assign dir_bits[e] = ctr_q[1];
      end
   endgenerate

   assign rd_taken = dir_bits[rd_idx];

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
   parameter int ADDR_W   = 32,
   parameter int ADDR_LSB = 2,
   parameter int IDX_W    = 8,
   parameter int HIST_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_taken,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              rs_valid,
   input  logic [ADDR_W-1:0] rs_addr,
   input  logic              rs_taken,
   input  logic [HIST_W-1:0] rs_hist,
   input  logic              rs_mispred
);

   generate
      if (HIST_W < 2 || HIST_W > IDX_W) begin : g_bad_hist
         $error("gshare_predictor: HIST_W must be in 2..IDX_W");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("gshare_predictor: IDX_W must be in 1..12");
      end
      if (ADDR_LSB + IDX_W > ADDR_W) begin : g_bad_addr
         $error("gshare_predictor: index slice exceeds address width");
      end
   endgenerate

   logic [HIST_W-1:0] hist_q;
   logic [IDX_W-1:0]  lk_idx;
   logic [IDX_W-1:0]  rs_idx;
   logic              pred_dir;
   logic              restore;

   assign restore = rs_valid & rs_mispred;

   gshare_index #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W))
   u_lk_index (.addr(lk_addr), .hist(hist_q), .idx(lk_idx));

   gshare_index #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W))
   u_rs_index (.addr(rs_addr), .hist(rs_hist), .idx(rs_idx));

   gshare_pht #(.IDX_W(IDX_W)) u_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_taken (pred_dir),
      .wr_en    (rs_valid),
      .wr_idx   (rs_idx),
      .wr_taken (rs_taken)
   );

   gshare_hist #(.HIST_W(HIST_W)) u_hist (
      .clk          (clk),
      .rst_n        (rst_n),
      .shift_en     (lk_valid),
      .shift_bit    (pred_dir),
      .restore_en   (restore),
      .restore_base (rs_hist[HIST_W-2:0]),
      .restore_bit  (rs_taken),
      .hist_q       (hist_q)
   );

   assign lk_taken = pred_dir;
   assign lk_hist  = hist_q;

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
   parameter int HIST_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              lk_taken,
   input logic [HIST_W-1:0] lk_hist,
   input logic              rs_valid,
   input logic              rs_taken,
   input logic [HIST_W-1:0] rs_hist,
   input logic              rs_mispred
);

   // R1
   hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (lk_hist == '0));

   // R5
   spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !(rs_valid && rs_mispred))
      |=> (lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(lk_taken)}));

   // R6
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_mispred)
      |=> (lk_hist == {$past(rs_hist[HIST_W-2:0]), $past(rs_taken)}));

   // R7
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !(rs_valid && rs_mispred)) |=> $stable(lk_hist));

endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_W(HIST_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_taken   (lk_taken),
   .lk_hist    (lk_hist),
   .rs_valid   (rs_valid),
   .rs_taken   (rs_taken),
   .rs_hist    (rs_hist),
   .rs_mispred (rs_mispred)
);

// File: tb/tb_gshare_predictor.sv
`timescale 1ns/1ps
module tb_gshare_predictor;

   localparam int AW = 16;
   localparam int HW = 4;
   localparam int IW = 4;
   localparam int LSB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_taken;
   logic [HW-1:0] lk_hist;
   logic          rs_valid = 1'b0;
   logic [AW-1:0] rs_addr = '0;
   logic          rs_taken = 1'b0;
   logic [HW-1:0] rs_hist = '0;
   logic          rs_mispred = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int          ref_ctr [16];
   logic [3:0]  ref_hist;

   always #2 clk = ~clk;

   gshare_predictor #(.ADDR_W(AW), .ADDR_LSB(LSB), .IDX_W(IW), .HIST_W(HW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_taken(lk_taken), .lk_hist(lk_hist),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
      .rs_hist(rs_hist), .rs_mispred(rs_mispred)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] idx_of(input logic [AW-1:0] a, input logic [3:0] h);
      return a[5:2] ^ h;
   endfunction

   task automatic step(input logic lv, input logic [AW-1:0] la,
                       input logic rv, input logic [AW-1:0] ra, input logic rt,
                       input logic [3:0] rh, input logic rm, input string tag,
                       output logic p, output logic [3:0] h);
      logic exp_p;
      lk_valid = lv; lk_addr = la;
      rs_valid = rv; rs_addr = ra; rs_taken = rt; rs_hist = rh; rs_mispred = rm;
      #1;
      exp_p = (ref_ctr[idx_of(la, ref_hist)] >= 2);
      p = lk_taken;
      h = lk_hist;
      chk(lk_taken == exp_p, {tag, " R2 R3 direction"}, int'(lk_taken), int'(exp_p));
      chk(lk_hist == ref_hist, {tag, " R5 R6 R7 history"}, int'(lk_hist), int'(ref_hist));
      if (rv) begin
         int k;
         k = idx_of(ra, rh);
         if (rt) ref_ctr[k] = (ref_ctr[k] == 3) ? 3 : ref_ctr[k] + 1;
         else    ref_ctr[k] = (ref_ctr[k] == 0) ? 0 : ref_ctr[k] - 1;
      end
      if (rv && rm)  ref_hist = {rh[2:0], rt};
      else if (lv)   ref_hist = {ref_hist[2:0], exp_p};
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic p, p2;
      logic [3:0] h, h2;
      logic [31:0] lfsr;
      int miss;

      for (int i = 0; i < 16; i++) ref_ctr[i] = 2;
      ref_hist = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: all counters weakly taken, history zero
      for (int i = 0; i < 16; i++) begin
         step(1'b0, AW'(i << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R1", p, h);
         chk(p == 1'b1, "R1 reset direction", int'(p), 1);
         chk(h == 4'h0, "R1 reset history", int'(h), 0);
      end

      // R3: saturation at 3 then descent to not taken
      for (int i = 0; i < 4; i++)
         step(1'b0, '0, 1'b1, AW'(5 << 2), 1'b1, 4'h0, 1'b0, "R3", p, h);
      step(1'b0, '0, 1'b1, AW'(5 << 2), 1'b0, 4'h0, 1'b0, "R3", p, h);
      step(1'b0, AW'(5 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R3", p, h);
      chk(p == 1'b1, "R3 saturated counter after one decrement", int'(p), 1);
      step(1'b0, '0, 1'b1, AW'(5 << 2), 1'b0, 4'h0, 1'b0, "R3", p, h);
      step(1'b0, AW'(5 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R3", p, h);
      chk(p == 1'b0, "R3 counter after two decrements", int'(p), 0);

      // R5: lookup shifts prediction into history; R7 resolve without restore holds
      step(1'b1, AW'(5 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R5", p, h);
      step(1'b0, '0, 1'b1, AW'(1 << 2), 1'b1, 4'h7, 1'b0, "R7", p2, h2);
      chk(h2 == {3'b000, p}, "R5 speculative shift", int'(h2), int'({3'b000, p}));
      step(1'b0, '0, 1'b0, '0, 1'b0, 4'h0, 1'b0, "R7", p2, h);
      chk(h == h2, "R7 history held", int'(h), int'(h2));

      // R6: restore overrides a same-cycle lookup
      step(1'b1, AW'(2 << 2), 1'b1, AW'(8 << 2), 1'b1, 4'b0110, 1'b1, "R6", p, h);
      step(1'b0, '0, 1'b0, '0, 1'b0, 4'h0, 1'b0, "R6", p, h);
      chk(h == 4'hD, "R6 restored history", int'(h), 13);

      // Pseudorandom mix checked against the model every cycle
      lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
         r = lfsr;
         step(r[0], AW'(r[11:4]), r[1], AW'(r[19:12]), r[2], r[23:20],
              (r[25:24] == 2'b00), "R2 mix", p, h);
      end

      // Bring history to zero: restore with base 000 and outcome 0
      step(1'b0, '0, 1'b1, AW'(15 << 2), 1'b0, 4'h0, 1'b1, "R4", p, h);

      // R4: train with a stale snapshot; only counter addr^snapshot moves
      for (int i = 0; i < 3; i++)
         step(1'b0, '0, 1'b1, AW'(3 << 2), 1'b1, 4'h0, 1'b0, "R4", p, h);
      for (int i = 0; i < 3; i++)
         step(1'b0, '0, 1'b1, AW'(3 << 2), 1'b0, 4'hA, 1'b0, "R4", p, h);
      step(1'b0, AW'(9 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R4", p, h);
      chk(p == 1'b0, "R4 snapshot-indexed counter trained", int'(p), 0);
      chk(h == 4'h0, "R4 current history untouched", int'(h), 0);
      step(1'b0, AW'(3 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R4", p, h);
      chk(p == 1'b1, "R4 current-history counter untouched", int'(p), 1);

      // R9: lookup and resolve on counter 9 in the same cycle (counter at 0)
      step(1'b0, AW'(9 << 2), 1'b1, AW'(9 << 2), 1'b1, 4'h0, 1'b0, "R9", p, h);
      chk(p == 1'b0, "R9 read before write, value 0", int'(p), 0);
      step(1'b0, AW'(9 << 2), 1'b1, AW'(9 << 2), 1'b1, 4'h0, 1'b0, "R9", p, h);
      chk(p == 1'b0, "R9 read before write, value 1", int'(p), 0);
      step(1'b0, AW'(9 << 2), 1'b0, '0, 1'b0, 4'h0, 1'b0, "R9", p, h);
      chk(p == 1'b1, "R9 update visible next cycle", int'(p), 1);

      // R8: alternating branch learned through global history
      miss = 0;
      for (int k = 0; k < 40; k++) begin
         logic act;
         act = k[0];
         step(1'b1, 16'h0040, 1'b0, '0, 1'b0, 4'h0, 1'b0, "R8", p, h);
         step(1'b0, '0, 1'b1, 16'h0040, act, h, (p != act), "R8", p2, h2);
         if (k >= 24 && p != act) miss++;
      end
      chk(miss == 0, "R8 alternating mispredicts after training", miss, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule